// File: doc/BRIEF.md
# UART Transmit Holding and Line-Status Logic

This block is the transmit half of a byte-wide serial port register model. Software writes bytes to a holding address. Depending on the FIFO-enable input, each byte lands either in a single holding register or in a circular transmit queue. The block then moves bytes one at a time into a shift register and offers each one to a downstream serializer over a valid/ready handshake.

The block also keeps three status bits. The holding-empty flag is set when nothing waits to be fetched. The transmitter-empty flag is set when the holding stage and the shift register are both idle. A pending flag records that the holding stage has become empty, and it produces the transmit interrupt when the enable input allows it. A read of the interrupt identification register clears the pending flag while the transmit interrupt is the active source. Changing the FIFO-enable input discards all bytes that are still held.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, thre=1, temt=1, thr_pend=0, irq=0 and out_valid=0.
- R2: A write with wr_en=1 and wr_addr equal to THR_ADDR (default 0) clears thre, temt and thr_pend on the next clock edge, in either mode.
- R3: With the FIFO mode in effect, bytes leave on out_data in write order. thre stays 0 while any byte remains queued, and it becomes 1 at the edge where the last queued byte moves into the shift register.
- R4: With the FIFO mode in effect, a holding write to a full queue (DEPTH entries) that does not coincide with a fetch discards the oldest queued byte and keeps the new one.
- R5: With the FIFO mode off, a fetch copies the holding register into the shift register and sets thre at that same edge.
- R6: thr_pend becomes 1 at the edge where thre goes from 0 to 1. irq is 1 exactly when thr_pend=1 and thre_ien=1.
- R7: While out_valid=1 and out_ready=0, out_valid stays 1 and out_data stays unchanged, and no new byte is fetched. With the FIFO mode off, a stalled byte and one later holding write are both sent, in that order.
- R8: temt=1 only when thre=1 and the shift register is empty (out_valid=0). It becomes 1 at the edge where the final byte is accepted (out_valid=1 and out_ready=1).
- R9: A pulse on iir_rd clears thr_pend only while irq=1. While thre_ien=0, an iir_rd pulse leaves thr_pend at 1.
- R10: When fifo_en differs from the mode in effect, the next edge discards every held byte (queue and holding register), sets thre, and adopts the new mode. The byte in the shift register is still sent.
- R11: Writes whose wr_addr differs from THR_ADDR change neither the status bits nor the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| fifo_en | input | 1 | Transmit queue enable (FIFO mode) |
| thre_ien | input | 1 | Holding-empty interrupt enable |
| iir_rd | input | 1 | Interrupt identification register read strobe |
| out_valid | output | 1 | Shift register holds a byte for the serializer |
| out_ready | input | 1 | Serializer accepts the byte |
| out_data | output | DATA_W | Byte in the shift register |
| thre | output | 1 | Holding stage empty |
| temt | output | 1 | Transmitter fully empty |
| thr_pend | output | 1 | Holding-empty interrupt pending |
| irq | output | 1 | Transmit interrupt |

## Verification
The bench stalls the serializer while bytes wait in the holding register. A design that fetched over a stalled byte would lose the first byte or send the bytes out of order. It overfills the queue by one byte and checks which byte is missing: a design that dropped the newest byte, or wrapped its count, would send the wrong sequence. It reads the interrupt identification register with the interrupt masked, to catch a design that clears the pending flag when the transmit interrupt is not active. It also toggles the FIFO enable with bytes queued, to check that the queue is flushed and the shift register byte is still sent. Every test checks that temt rises only after the last handshake, which catches a design that sets temt as soon as the holding stage empties.

// File: rtl/uart_tx_hold_pkg.sv
package uart_tx_hold_pkg;
   typedef enum logic {
      HOLD_SINGLE = 1'b0,
      HOLD_QUEUE  = 1'b1
   } hold_mode_e;
endpackage

// File: rtl/uart_tx_hold_fifo.sv
module uart_tx_hold_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_tx_hold_fifo: DEPTH must be at least 2");
   end

   logic [PW-1:0] rd_ptr_q, wr_ptr_q;
   logic [CW-1:0] cnt_q;
   logic          full, drop;
   logic [W-1:0]  slot_view [DEPTH];

   assign full  = (cnt_q == CW'(DEPTH));
   assign drop  = push & full & ~pop;
   assign count = cnt_q;
   assign head  = slot_view[rd_ptr_q];

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (push && !flush && wr_ptr_q == PW'(i)) begin
            slot_q <= din;
         end
      end
      assign slot_view[i] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (flush) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) begin
            wr_ptr_q <= step(wr_ptr_q);
         end
         if (pop || drop) begin
            rd_ptr_q <= step(rd_ptr_q);
         end
         if (push && !pop && !full) begin
            cnt_q <= cnt_q + CW'(1);
         end else if (pop && !push) begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end
endmodule

// File: rtl/uart_tx_hold_status.sv
module uart_tx_hold_status (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_wr,
   input  logic fetch,
   input  logic fetch_empties,
   input  logic flush,
   input  logic tsr_full_next,
   input  logic pend_clear,
   output logic thre,
   output logic temt,
   output logic pend
);
   logic thre_q, temt_q, pend_q;
   logic thre_n, pend_n;

   always_comb begin
      thre_n = thre_q;
      if (hold_wr) begin
         thre_n = 1'b0;
      end else if (flush || (fetch && fetch_empties)) begin
         thre_n = 1'b1;
      end

      pend_n = pend_q;
      if (hold_wr) begin
         pend_n = 1'b0;
      end else if (thre_n && !thre_q && !pend_q) begin
         pend_n = 1'b1;
      end else if (pend_clear) begin
         pend_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thre_q <= 1'b1;
         temt_q <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         thre_q <= thre_n;
         temt_q <= thre_n & ~tsr_full_next;
         pend_q <= pend_n;
      end
   end

   assign thre = thre_q;
   assign temt = temt_q;
   assign pend = pend_q;
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
   import uart_tx_hold_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter int          ADDR_W   = 3,
   parameter int          DEPTH    = 16,
   parameter logic [ADDR_W-1:0] THR_ADDR = '0,
   localparam int         CW       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fifo_en,
   input  logic              thre_ien,
   input  logic              iir_rd,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              thre,
   output logic              temt,
   output logic              thr_pend,
   output logic              irq
);
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("uart_tx_hold: widths must be positive");
   end

   hold_mode_e        mode_q;
   logic              flush, hold_wr, send, fetch, fetch_empties, tsr_full_n;
   logic [DATA_W-1:0] thr_q, tsr_q, fifo_head, fetch_byte;
   logic              tsr_full_q;
   logic [CW-1:0]     fifo_cnt;

   assign flush   = (hold_mode_e'(fifo_en) != mode_q);
   assign hold_wr = wr_en & (wr_addr == THR_ADDR) & ~flush;
   assign send    = tsr_full_q & out_ready;
   assign fetch   = ~thre & (~tsr_full_q | send) & ~flush;
   assign tsr_full_n = fetch | (tsr_full_q & ~send);

   assign fetch_empties = (mode_q == HOLD_QUEUE) ? (fifo_cnt == CW'(1)) : 1'b1;
   assign fetch_byte    = (mode_q == HOLD_QUEUE) ? fifo_head : thr_q;

   uart_tx_hold_fifo #(
      .W     (DATA_W),
      .DEPTH (DEPTH)
   ) fifo_i (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (hold_wr & (mode_q == HOLD_QUEUE)),
      .pop   (fetch & (mode_q == HOLD_QUEUE)),
      .din   (wr_data),
      .head  (fifo_head),
      .count (fifo_cnt)
   );

   uart_tx_hold_status status_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .hold_wr       (hold_wr),
      .fetch         (fetch),
      .fetch_empties (fetch_empties),
      .flush         (flush),
      .tsr_full_next (tsr_full_n),
      .pend_clear    (iir_rd & irq),
      .thre          (thre),
      .temt          (temt),
      .pend          (thr_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= HOLD_SINGLE;
         thr_q      <= '0;
         tsr_q      <= '0;
         tsr_full_q <= 1'b0;
      end else begin
         if (flush) begin
            mode_q <= hold_mode_e'(fifo_en);
         end
         if (hold_wr && mode_q == HOLD_SINGLE) begin
            thr_q <= wr_data;
         end
         if (fetch) begin
            tsr_q <= fetch_byte;
         end
         tsr_full_q <= tsr_full_n;
      end
   end

   assign out_valid = tsr_full_q;
   assign out_data  = tsr_q;
   assign irq       = thr_pend & thre_ien;
endmodule

// File: rtl/uart_tx_hold_chk.sv
module uart_tx_hold_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_wr,
   input logic [CW-1:0]     fifo_cnt,
   input logic              thre_ien,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              thre,
   input logic              temt,
   input logic              thr_pend,
   input logic              irq
);
   a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hold_wr |=> (!thre && !temt && !thr_pend));

   a_r8_temt_idle: assert property (@(posedge clk) disable iff (!rst_n)
      temt |-> (thre && !out_valid));

   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   a_r6_rise_pend: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thre) |-> thr_pend);

   a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (thr_pend && thre_ien));

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(DEPTH));
endmodule

bind uart_tx_hold uart_tx_hold_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .hold_wr   (hold_wr),
   .fifo_cnt  (fifo_cnt),
   .thre_ien  (thre_ien),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .thre      (thre),
   .temt      (temt),
   .thr_pend  (thr_pend),
   .irq       (irq)
);

// File: tb/uart_tx_hold_tb_top.sv
`timescale 1ns/1ps
module uart_tx_hold_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       fifo_en = 1'b0;
   logic       thre_ien = 1'b1;
   logic       iir_rd = 1'b0;
   logic       out_ready = 1'b0;
   logic       out_valid, thre, temt, thr_pend, irq;
   logic [7:0] out_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   uart_tx_hold dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .fifo_en(fifo_en), .thre_ien(thre_ien),
      .iir_rd(iir_rd), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .thre(thre), .temt(temt),
      .thr_pend(thr_pend), .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic write_hold(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic drain(input string tag, input logic [7:0] exp_q[$]);
      logic [7:0] got_q[$];
      out_ready = 1'b1;
      for (int c = 0; c < 4 * exp_q.size() + 8; c++) begin
         if (out_valid) got_q.push_back(out_data);
         @(negedge clk);
      end
      chk({tag, " byte count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk({tag, " byte order"}, got_q[i], exp_q[i]);
      chk("R8 temt after drain", temt, 1);
      chk("R8 idle after drain", out_valid, 0);
      out_ready = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 thre", thre, 1);
      chk("R1 temt", temt, 1);
      chk("R1 pend", thr_pend, 0);
      chk("R1 irq", irq, 0);
      chk("R1 valid", out_valid, 0);
   endtask

   task automatic t_single_byte;
      out_ready = 1'b1;
      write_hold(3'd0, 8'hA5);
      chk("R2 thre cleared", thre, 0);
      chk("R2 temt cleared", temt, 0);
      @(negedge clk);
      chk("R5 valid after load", out_valid, 1);
      chk("R5 data", out_data, 8'hA5);
      chk("R5 thre set at load", thre, 1);
      chk("R8 temt while shifting", temt, 0);
      chk("R6 pend on thre rise", thr_pend, 1);
      chk("R6 irq enabled", irq, 1);
      @(negedge clk);
      chk("R8 temt after accept", temt, 1);
      out_ready = 1'b0;
   endtask

   task automatic t_iir;
      thre_ien = 1'b0;
      #0;
      chk("R6 irq masked", irq, 0);
      iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0;
      chk("R9 masked read keeps pend", thr_pend, 1);
      thre_ien = 1'b1;
      iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0;
      chk("R9 active read clears pend", thr_pend, 0);
      chk("R9 irq low", irq, 0);
   endtask

   task automatic t_other_addr;
      write_hold(3'd3, 8'h77);
      @(negedge clk);
      chk("R11 thre kept", thre, 1);
      chk("R11 temt kept", temt, 1);
      chk("R11 no output", out_valid, 0);
   endtask

   task automatic t_single_stall;
      write_hold(3'd0, 8'h11);
      @(negedge clk);
      chk("R2 pend cleared then reset by load", thr_pend, 1);
      write_hold(3'd0, 8'h22);
      chk("R2 pend cleared by write", thr_pend, 0);
      @(negedge clk);
      chk("R7 stalled valid", out_valid, 1);
      chk("R7 stalled data", out_data, 8'h11);
      chk("R7 thre clear with pending byte", thre, 0);
      drain("R7 stalled+held", '{8'h11, 8'h22});
   endtask

   task automatic t_fifo_order;
      fifo_en = 1'b1;
      @(negedge clk); @(negedge clk);
      write_hold(3'd0, 8'h31);
      write_hold(3'd0, 8'h32);
      write_hold(3'd0, 8'h33);
      @(negedge clk);
      chk("R3 thre clear while queued", thre, 0);
      chk("R7 head waits", out_data, 8'h31);
      drain("R3 fifo order", '{8'h31, 8'h32, 8'h33});
      chk("R3 thre set after last pop", thre, 1);
   endtask

   task automatic t_overflow;
      logic [7:0] exp_q[$];
      for (int i = 0; i < 18; i++) write_hold(3'd0, 8'(8'h40 + i));
      exp_q.push_back(8'h40);
      for (int i = 2; i < 18; i++) exp_q.push_back(8'(8'h40 + i));
      drain("R4 drop oldest", exp_q);
   endtask

   task automatic t_flush;
      write_hold(3'd0, 8'h51);
      write_hold(3'd0, 8'h52);
      write_hold(3'd0, 8'h53);
      chk("R10 pend clear before flush", thr_pend, 0);
      fifo_en = 1'b0;
      @(negedge clk);
      chk("R10 thre set by flush", thre, 1);
      chk("R10 pend raised by flush", thr_pend, 1);
      chk("R10 shift byte kept", out_data, 8'h51);
      drain("R10 only shift byte", '{8'h51});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_byte();
      t_iir();
      t_other_addr();
      t_single_stall();
      t_fifo_order();
      t_overflow();
      t_flush();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule